// File: doc/BRIEF.md
# Circular-Pointer Hardware Stack

A push-down stack for a stack-machine CPU, usable as either the return stack or the parameter stack. The top item lives in its own register, so it is visible at once to an ALU or a branch unit. Deeper items live in a small RAM of `DEPTH` words. A one-hot ring pointer marks the RAM word directly beneath the top.

A push moves the old top into the RAM and loads a new value into the top register. A pop reloads the top register from the RAM. A replace-top write changes the top register alone. Every operation takes one clock.

The word beneath the top is driven combinationally on `next_o`. This gives two-operand units both stack items without an extra cycle. The pointer is circular, so there is no overflow or underflow detection. Deep pushes silently overwrite the oldest word, and excess pops keep reading old RAM contents in ring order.

Top module: `stk_circ_stack`

## Requirements
- R1: After reset, `top_o` is 0 and the pointer is at ring position 0. Until something is written, the RAM content is undefined.
- R2: A push (`push_i`=1) makes `top_o` equal to the `data_i` present at that edge. From the next cycle, `next_o` equals the `top_o` value from before the push.
- R3: A pop (`pop_i`=1, `push_i`=0, `wr_top_i`=0) makes `top_o` equal to the `next_o` value from before the edge. `next_o` then shows the word that sat one place deeper.
- R4: A replace-top (`wr_top_i`=1, `push_i`=0, `pop_i`=0) makes `top_o` equal to `data_i` and leaves `next_o` unchanged.
- R5: A pop together with a replace-top (`pop_i`=1, `wr_top_i`=1, `push_i`=0) loads `data_i` into `top_o` and discards the popped word. `next_o` then shows the word two places below the old top.
- R6: When `push_i` and `pop_i` are both high, the push takes effect and `pop_i` is ignored. The result matches R2.
- R7: With all three controls low, `top_o` and `next_o` hold their values.
- R8: The ring has `DEPTH` RAM words. After more than `DEPTH` pushes, the oldest words are overwritten with no fault. A run of `DEPTH`+1 pops from a full ring returns, on the last pop, the same value as the first pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push `data_i`; old top moves into the RAM |
| pop_i | input | 1 | Pop; top reloads from the RAM |
| wr_top_i | input | 1 | Write `data_i` into the top register |
| data_i | input | WIDTH | Value for push or replace-top |
| top_o | output | WIDTH | Top-of-stack register |
| next_o | output | WIDTH | Word directly beneath the top |

## Verification
Two functions can land in the same cycle: a pop and a replace-top, which is the usual binary-operation case. Push and pop can also be raised together. The bench drives both pairings in one clock, after several pushes of distinct values. It then checks three things: `top_o` takes `data_i`, `next_o` exposes the word two levels down for the pop-and-write case, and the RAM behaves exactly as for a lone push for the push-and-pop case. A reference ring model in the scoreboard keeps expected values correct through wrap-around, where a wrong pointer direction would surface.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_SET  = 2'd3
  } stk_op_e;

  function automatic stk_op_e stk_decode(input logic push, input logic pop, input logic set);
    if (push)      return STK_PUSH;
    else if (pop)  return STK_POP;
    else if (set)  return STK_SET;
    else           return STK_HOLD;
  endfunction
endpackage

// File: rtl/stk_ring_ptr.sv
module stk_ring_ptr #(
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             ret_i,
  output logic [DEPTH-1:0] ptr_o,
  output logic [DEPTH-1:0] ptr_fwd_o
);
  logic [DEPTH-1:0] ptr_q, ptr_d, ptr_bwd;

  assign ptr_fwd_o = {ptr_q[DEPTH-2:0], ptr_q[DEPTH-1]};
  assign ptr_bwd   = {ptr_q[0], ptr_q[DEPTH-1:1]};

  always_comb begin
    ptr_d = ptr_q;
    if (adv_i)      ptr_d = ptr_fwd_o;
    else if (ret_i) ptr_d = ptr_bwd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= {{(DEPTH-1){1'b0}}, 1'b1};
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [DEPTH-1:0] wsel_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [DEPTH-1:0] rsel_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (we_i && wsel_i[g]) mem[g] <= wdata_i;
    end
  end

  // one-hot select: AND-OR read, no decoder
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rdata_o = rdata_o | (mem[i] & {WIDTH{rsel_i[i]}});
    end
  end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             wr_top_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] rd_data_i,
  output logic [WIDTH-1:0] top_o,
  output logic             ram_we_o,
  output logic             adv_o,
  output logic             ret_o
);
  stk_op_e          op;
  logic [WIDTH-1:0] top_q, top_d;

  assign op = stk_decode(push_i, pop_i, wr_top_i);

  always_comb begin
    top_d    = top_q;
    ram_we_o = 1'b0;
    adv_o    = 1'b0;
    ret_o    = 1'b0;
    unique case (op)
      STK_PUSH: begin
        top_d    = data_i;
        ram_we_o = 1'b1;
        adv_o    = 1'b1;
      end
      STK_POP: begin
        top_d = wr_top_i ? data_i : rd_data_i;
        ret_o = 1'b1;
      end
      STK_SET:  top_d = data_i;
      default:  top_d = top_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) top_q <= '0;
    else         top_q <= top_d;
  end

  assign top_o = top_q;
endmodule

// File: rtl/stk_circ_stack.sv
module stk_circ_stack #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             wr_top_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] top_o,
  output logic [WIDTH-1:0] next_o
);
  logic [DEPTH-1:0] ptr, ptr_fwd;
  logic             ram_we, adv, ret;
  logic [WIDTH-1:0] rd_data;

  stk_ring_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .ret_i     (ret),
    .ptr_o     (ptr),
    .ptr_fwd_o (ptr_fwd)
  );

  stk_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .wsel_i  (ptr_fwd),
    .wdata_i (top_o),
    .rsel_i  (ptr),
    .rdata_o (rd_data)
  );

  stk_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .wr_top_i  (wr_top_i),
    .data_i    (data_i),
    .rd_data_i (rd_data),
    .top_o     (top_o),
    .ram_we_o  (ram_we),
    .adv_o     (adv),
    .ret_o     (ret)
  );

  assign next_o = rd_data;
endmodule

// File: rtl/stk_circ_stack_chk.sv
module stk_circ_stack_chk #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             pop_i,
  input logic             wr_top_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] top_o,
  input logic [WIDTH-1:0] next_o,
  input logic [DEPTH-1:0] ptr_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_TOP: assert (top_o == '0); // R1
  end

  AST_PTR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ptr_i) == 1); // R8

  AST_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(data_i)); // R2

  AST_PUSH_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> next_o == $past(top_o)); // R2

  AST_PUSH_BEATS_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> (next_o == $past(top_o)) && (ptr_i == {$past(ptr_i[DEPTH-2:0]), $past(ptr_i[DEPTH-1])})); // R6

  AST_POP_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !wr_top_i) |=> top_o == $past(next_o)); // R3

  AST_SET_KEEPS_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_top_i && !push_i && !pop_i) |=> (top_o == $past(data_i)) && $stable(next_o)); // R4

  AST_POP_SET_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && wr_top_i && !push_i) |=> top_o == $past(data_i)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i && !wr_top_i) |=> $stable(top_o) && $stable(ptr_i)); // R7
endmodule

bind stk_circ_stack stk_circ_stack_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .push_i   (push_i),
  .pop_i    (pop_i),
  .wr_top_i (wr_top_i),
  .data_i   (data_i),
  .top_o    (top_o),
  .next_o   (next_o),
  .ptr_i    (ptr)
);

// File: tb/test_stk_circ_stack.sv
`timescale 1ns/1ps
module test_stk_circ_stack;
  localparam int WIDTH = 18;
  localparam int DEPTH = 16;

  typedef struct {
    logic [WIDTH-1:0] top;
    logic [WIDTH-1:0] nxt;
    bit               top_ok;
    bit               nxt_ok;
    string            req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             push = 1'b0, pop = 1'b0, wr_top = 1'b0;
  logic [WIDTH-1:0] data = '0;
  logic [WIDTH-1:0] top_o, next_o;

  int n_chk = 0, n_bad = 0;
  exp_t sb [$];

  // reference ring model
  logic [WIDTH-1:0] m_mem [DEPTH];
  bit               m_wr  [DEPTH];
  int               m_p = 0;
  logic [WIDTH-1:0] m_top = '0;
  bit               m_top_ok = 1'b1;
  logic [WIDTH-1:0] first_pop;

  always #2.5 clk = ~clk;

  stk_circ_stack #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_stk_circ_stack (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .pop_i(pop),
    .wr_top_i(wr_top), .data_i(data), .top_o(top_o), .next_o(next_o)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: apply at negedge, enqueue expected state after next posedge
  task automatic drive(input bit pu, input bit po, input bit st, input logic [WIDTH-1:0] d, input string req);
    exp_t e;
    @(negedge clk);
    push = pu; pop = po; wr_top = st; data = d;
    if (pu) begin
      m_p = (m_p + 1) % DEPTH;
      m_mem[m_p] = m_top; m_wr[m_p] = m_top_ok;
      m_top = d; m_top_ok = 1'b1;
    end else if (po) begin
      if (st) begin m_top = d; m_top_ok = 1'b1; end
      else    begin m_top = m_mem[m_p]; m_top_ok = m_wr[m_p]; end
      m_p = (m_p + DEPTH - 1) % DEPTH;
    end else if (st) begin
      m_top = d; m_top_ok = 1'b1;
    end
    e.top = m_top; e.top_ok = m_top_ok;
    e.nxt = m_mem[m_p]; e.nxt_ok = m_wr[m_p];
    e.req = req;
    sb.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      if (e.top_ok) check({e.req, " top"}, top_o, e.top);
      if (e.nxt_ok) check({e.req, " next"}, next_o, e.nxt);
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_wr[i] = 1'b0; end
    #12 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset top", top_o, '0);

    // R1, R2: first push writes reset top into slot after position 0
    drive(1, 0, 0, 18'h0_1111, "R1_R2 push");
    drive(1, 0, 0, 18'h0_2222, "R2 push");
    drive(1, 0, 0, 18'h3_ABCD, "R2 push");
    drive(1, 0, 0, 18'h2_5A5A, "R2 push");
    // R7 idle
    drive(0, 0, 0, 18'h3_FFFF, "R7 idle");
    drive(0, 0, 0, 18'h1_2345, "R7 idle");
    // R4 replace-top
    drive(0, 0, 1, 18'h1_0F0F, "R4 set");
    // R3 pop
    drive(0, 1, 0, 18'h3_3333, "R3 pop");
    // R5 pop with replace
    drive(1, 0, 0, 18'h0_0777, "R2 push");
    drive(0, 1, 1, 18'h2_C0DE, "R5 pop_set");
    // R6 push and pop together
    drive(1, 1, 0, 18'h1_BEEF, "R6 push_pop");
    drive(1, 1, 1, 18'h0_4444, "R6 push_pop_set");
    drive(0, 1, 0, 18'h0, "R3 pop");
    drive(0, 1, 0, 18'h0, "R3 pop");

    // R8 overflow: push well past ring size
    for (int i = 0; i < DEPTH + 5; i++)
      drive(1, 0, 0, WIDTH'(18'h1_0000 + i * 18'h0_0101), "R8 fill");
    for (int i = 0; i <= DEPTH; i++) begin
      drive(0, 1, 0, 18'h0, "R8 drain");
      if (i == 0) begin
        @(posedge clk); #1.5; first_pop = top_o;
      end
    end
    @(posedge clk); #1.5;
    check("R8 wrap repeat", top_o, first_pop);

    drive(0, 0, 0, 18'h0, "R7 idle");
    @(negedge clk);
    @(negedge clk);
    push = 0; pop = 0; wr_top = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule